// File: doc/BRIEF.md
# Dual Reference Clock Selector with Loss Supervision

This block decides which of two references, both running at the same frequency, feeds a downstream frequency synthesiser. Both references are sampled by a faster system clock. A monitor watches each one and raises a loss alarm when its edges stop. The alarm is sticky: it clears only after the reference has been qualified again over several consecutive observation windows. A mode strap picks one of three policies. In manual mode a filtered select line decides the source. In non-revertive automatic mode the block moves away from a failed source and stays on the new one. In revertive automatic mode the block always goes back to input 1 once input 1 is healthy.

When both references are in alarm the block enters hold. The hold flag tells the synthesiser to freeze its frequency control word, and the active-source indicator keeps showing the last source that was in use. In the automatic modes the select pad turns into an output, and `act_drive` enables its driver. A one-cycle strobe marks every change of the active source. While reset is asserted, the clock outputs downstream are marked as disabled.

Top module: `dual_ref_selector`

## Requirements
- R1: While `rst_n` is low, `out_en` and `act_drive` are 0. In the first cycle after release, both alarms read 1, `hold` reads 1 and `act_src` reads 0, with no reference running.
- R2: An alarm rises once its reference has had no rising edge for TIMEOUT_CYC (32) system cycles, plus synchronizer delay. Normal edge spacing never raises it.
- R3: An alarm, once set, clears only after QUAL_WINS (4) consecutive free-running windows of TIMEOUT_CYC cycles each contain at least one edge. A shorter burst of edges leaves it set.
- R4: With `mode_sel` = 2'b00 (manual) and not both alarms set, `act_src` follows the filtered select: 0 picks input 1 and 1 picks input 2. This holds even if the picked input is in alarm.
- R5: A change on `sel_in` takes effect only after the synchronized level has differed from the accepted level for DEGLITCH_CYC (16) consecutive cycles. Shorter pulses have no effect on `act_src`.
- R6: With `mode_sel` = 2'b10 or 2'b11 (revertive), `act_src` is 0 whenever input 1 has no alarm. Otherwise it is 1.
- R7: With `mode_sel` = 2'b01 (non-revertive), the block changes source only when the current source is in alarm. It stays on input 2 after input 1 recovers.
- R8: When both alarms are set, `hold` becomes 1 and `act_src` keeps its last value.
- R9: Hold ends as soon as either alarm clears. In the automatic modes it picks input 1 if input 1 is valid, else input 2; in manual mode it picks the filtered select.
- R10: `sw_pulse` is high for exactly the cycle in which `act_src` shows a new value, and at no other time.
- R11: `act_drive` is 1 out of reset in either automatic mode and 0 in manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference input 1, sampled |
| ref_b | input | 1 | Reference input 2, sampled |
| mode_sel | input | 2 | 00 manual, 01 non-revertive, 1x revertive |
| sel_in | input | 1 | Manual source select (0 = input 1) |
| los_a | output | 1 | Sticky loss alarm for input 1 |
| los_b | output | 1 | Sticky loss alarm for input 2 |
| act_src | output | 1 | Active source (0 = input 1, 1 = input 2) |
| act_drive | output | 1 | Output enable of the select pad in automatic modes |
| hold | output | 1 | Both inputs lost; frequency control frozen |
| sw_pulse | output | 1 | One-cycle strobe on each change of active source |
| out_en | output | 1 | Low while reset is held |

## Verification
Leaving hold and choosing a preferred source can happen in the same cycle. The bench provokes this by stopping input 1 and then input 2 in non-revertive mode, so the block ends in hold on input 2. It then restarts both references with one shared phase, so both alarms clear on the same edge. A correct design must come out of hold straight onto input 1 and raise exactly one switch strobe. The bench also counts strobes against observed changes of `act_src` across the whole run.

// File: rtl/drs_pkg.sv
package drs_pkg;

   typedef enum logic [1:0] {
      POL_MAN    = 2'd0,
      POL_NONREV = 2'd1,
      POL_REV    = 2'd2
   } pol_e;

   // strap decode: 00 manual, 01 non-revertive, 1x revertive
   function automatic pol_e decode_mode(input logic [1:0] strap);
      pol_e p;
      case (strap)
         2'b00:   p = POL_MAN;
         2'b01:   p = POL_NONREV;
         default: p = POL_REV;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/drs_win_timer.sv
module drs_win_timer #(
   parameter int WIN_CYC = 32
) (
   input  logic clk_sys,
   input  logic rst_n,
   output logic win_end
);
   localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

   if (WIN_CYC < 4) begin : g_bad_win
      $error("drs_win_timer: WIN_CYC must be at least 4");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign win_end = (cnt_q == LAST);

   // R3 windows are back to back: a window end is followed by a fresh count
   a_r3_window_restart: assert property (@(posedge clk_sys) disable iff (!rst_n)
      win_end |=> (cnt_q == '0));

endmodule

// File: rtl/drs_los_mon.sv
module drs_los_mon #(
   parameter int TIMEOUT_CYC  = 32,
   parameter int QUAL_WINS    = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit BOTH_EDGES   = 1'b0
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic ref_in,
   input  logic win_end,
   output logic los
);
   localparam int GW = $clog2(TIMEOUT_CYC);
   localparam int QW = (QUAL_WINS > 1) ? $clog2(QUAL_WINS) : 1;
   localparam logic [GW-1:0] GAP_LAST  = GW'(TIMEOUT_CYC - 1);
   localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_WINS - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("drs_los_mon: SYNC_STAGES must be at least 2");
   end
   if (QUAL_WINS < 2) begin : g_bad_qual
      $error("drs_los_mon: QUAL_WINS must be at least 2");
   end
   if (TIMEOUT_CYC < 4) begin : g_bad_to
      $error("drs_los_mon: TIMEOUT_CYC must be at least 4");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   edge_seen;
   logic [GW-1:0]          gap_q;
   logic [QW-1:0]          good_q;
   logic                   seen_q;
   logic                   los_q;
   logic                   win_ok;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   if (BOTH_EDGES) begin : g_any_edge
      assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
   end else begin : g_rise_edge
      assign edge_seen = sync_q[SYNC_STAGES-1] & ~prev_q;
   end

   // an edge in the closing cycle still belongs to the closing window
   assign win_ok = seen_q | edge_seen;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         gap_q  <= '0;
         good_q <= '0;
         los_q  <= 1'b1;
      end else begin
         if (win_end)        seen_q <= 1'b0;
         else if (edge_seen) seen_q <= 1'b1;

         if (los_q) begin
            gap_q <= '0;
            if (win_end) begin
               if (!win_ok) begin
                  good_q <= '0;
               end else if (good_q == QUAL_LAST) begin
                  good_q <= '0;
                  los_q  <= 1'b0;
               end else begin
                  good_q <= good_q + 1'b1;
               end
            end
         end else begin
            good_q <= '0;
            if (edge_seen) begin
               gap_q <= '0;
            end else if (gap_q == GAP_LAST) begin
               gap_q <= '0;
               los_q <= 1'b1;
            end else begin
               gap_q <= gap_q + 1'b1;
            end
         end
      end
   end

   assign los = los_q;

   // R3 the alarm stays set unless the last qualifying window just closed
   a_r3_alarm_sticky: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (los_q && !(win_end && win_ok && good_q == QUAL_LAST)) |=> los_q);

   // R2 a fresh edge never raises the alarm
   a_r2_edge_keeps_clear: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (!los_q && edge_seen) |=> !los_q);

endmodule

// File: rtl/drs_sel_filter.sv
module drs_sel_filter #(
   parameter int DEGLITCH_CYC = 16,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic sel_in,
   output logic sel_filt
);
   localparam int RW = $clog2(DEGLITCH_CYC);
   localparam logic [RW-1:0] RUN_LAST = RW'(DEGLITCH_CYC - 1);

   if (DEGLITCH_CYC < 2) begin : g_bad_dg
      $error("drs_sel_filter: DEGLITCH_CYC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("drs_sel_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   filt_q;
   logic [RW-1:0]          run_q;
   logic                   raw;

   assign raw = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         filt_q <= 1'b0;
         run_q  <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], sel_in};
         if (raw == filt_q) begin
            run_q <= '0;
         end else if (run_q == RUN_LAST) begin
            run_q  <= '0;
            filt_q <= raw;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign sel_filt = filt_q;

   // R5 the accepted level moves only after a full run of differing samples
   a_r5_full_run: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !$stable(filt_q) |-> ($past(run_q) == RUN_LAST));

endmodule

// File: rtl/drs_arbiter.sv
module drs_arbiter
   import drs_pkg::*;
(
   input  logic clk_sys,
   input  logic rst_n,
   input  pol_e pol,
   input  logic man_sel,
   input  logic los_a,
   input  logic los_b,
   output logic act_src,
   output logic hold,
   output logic sw_pulse
);
   logic act_q, act_d;
   logic hold_q, hold_d;
   logic sw_q;
   logic both_lost;
   logic cur_lost;

   assign both_lost = los_a & los_b;
   assign cur_lost  = act_q ? los_b : los_a;

   always_comb begin
      act_d  = act_q;
      hold_d = hold_q;
      if (both_lost) begin
         hold_d = 1'b1;
      end else begin
         hold_d = 1'b0;
         case (pol)
            POL_MAN:    act_d = man_sel;
            POL_REV:    act_d = los_a;
            default: begin
               if (hold_q || cur_lost) act_d = los_a;
            end
         endcase
      end
   end

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hold_q <= 1'b1;
         sw_q   <= 1'b0;
      end else begin
         act_q  <= act_d;
         hold_q <= hold_d;
         sw_q   <= act_d ^ act_q;
      end
   end

   assign act_src  = act_q;
   assign hold     = hold_q;
   assign sw_pulse = sw_q;

   // R4 manual mode follows the filtered select
   a_r4_manual_follow: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (pol == POL_MAN && !both_lost) |=> (act_q == $past(man_sel)));

   // R6 revertive mode sits on input 1 whenever it is healthy
   a_r6_revert_home: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (pol == POL_REV && !los_a) |=> (act_q == 1'b0));

   // R7 non-revertive mode keeps a healthy input 2
   a_r7_no_revert: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (pol == POL_NONREV && !hold_q && act_q && !los_b) |=> act_q);

   // R8 both alarms freeze the source and raise hold
   a_r8_hold_freeze: assert property (@(posedge clk_sys) disable iff (!rst_n)
      both_lost |=> (hold_q && act_q == $past(act_q)));

   // R9 leaving hold in an automatic mode prefers a valid input 1
   a_r9_exit_pref: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (hold_q && !los_a && pol != POL_MAN) |=> (!hold_q && !act_q));

   // R10 the strobe marks exactly the cycles with a new source
   a_r10_strobe_match: assert property (@(posedge clk_sys) disable iff (!rst_n)
      1'b1 |-> (sw_q == (act_q != $past(act_q))));

endmodule

// File: rtl/dual_ref_selector.sv
module dual_ref_selector
   import drs_pkg::*;
#(
   parameter int TIMEOUT_CYC  = 32,
   parameter int QUAL_WINS    = 4,
   parameter int DEGLITCH_CYC = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit BOTH_EDGES   = 1'b0
) (
   input  logic       clk_sys,
   input  logic       rst_n,
   input  logic       ref_a,
   input  logic       ref_b,
   input  logic [1:0] mode_sel,
   input  logic       sel_in,
   output logic       los_a,
   output logic       los_b,
   output logic       act_src,
   output logic       act_drive,
   output logic       hold,
   output logic       sw_pulse,
   output logic       out_en
);
   localparam int NUM_REF = 2;

   logic [NUM_REF-1:0] ref_vec;
   logic [NUM_REF-1:0] los_vec;
   logic               win_end;
   logic               man_sel;
   logic               out_en_q;
   pol_e               pol;

   assign ref_vec = {ref_b, ref_a};
   assign pol     = decode_mode(mode_sel);

   drs_win_timer #(
      .WIN_CYC (TIMEOUT_CYC)
   ) win_i (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .win_end (win_end)
   );

   for (genvar i = 0; i < NUM_REF; i++) begin : g_mon
      drs_los_mon #(
         .TIMEOUT_CYC (TIMEOUT_CYC),
         .QUAL_WINS   (QUAL_WINS),
         .SYNC_STAGES (SYNC_STAGES),
         .BOTH_EDGES  (BOTH_EDGES)
      ) mon_i (
         .clk_sys (clk_sys),
         .rst_n   (rst_n),
         .ref_in  (ref_vec[i]),
         .win_end (win_end),
         .los     (los_vec[i])
      );
   end

   drs_sel_filter #(
      .DEGLITCH_CYC (DEGLITCH_CYC),
      .SYNC_STAGES  (SYNC_STAGES)
   ) filt_i (
      .clk_sys  (clk_sys),
      .rst_n    (rst_n),
      .sel_in   (sel_in),
      .sel_filt (man_sel)
   );

   drs_arbiter arb_i (
      .clk_sys  (clk_sys),
      .rst_n    (rst_n),
      .pol      (pol),
      .man_sel  (man_sel),
      .los_a    (los_vec[0]),
      .los_b    (los_vec[1]),
      .act_src  (act_src),
      .hold     (hold),
      .sw_pulse (sw_pulse)
   );

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) out_en_q <= 1'b0;
      else        out_en_q <= 1'b1;
   end

   assign los_a     = los_vec[0];
   assign los_b     = los_vec[1];
   assign out_en    = out_en_q;
   assign act_drive = out_en_q & (pol != POL_MAN);

   // R1 outputs are marked disabled while reset is held
   always @(posedge clk_sys) begin
      if (!rst_n) begin
         a_r1_reset_disables: assert (!out_en_q && !act_drive);
      end
   end

   // R11 the select pad is driven only in the automatic modes
   a_r11_pad_drive: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (mode_sel == 2'b00) |-> !act_drive);

endmodule

// File: tb/dual_ref_selector_tb_top.sv
module dual_ref_selector_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_a = 1'b0;
   logic       ref_b = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       sel_in = 1'b0;
   logic       los_a, los_b, act_src, act_drive, hold, sw_pulse, out_en;

   logic       run_a = 1'b0;
   logic       run_b = 1'b0;
   logic [2:0] ph = '0;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int changes = 0;
   logic prev_act = 1'b0;
   logic mon_on = 1'b0;

   always #4 clk = ~clk;

   dual_ref_selector dut_i (
      .clk_sys   (clk),
      .rst_n     (rst_n),
      .ref_a     (ref_a),
      .ref_b     (ref_b),
      .mode_sel  (mode_sel),
      .sel_in    (sel_in),
      .los_a     (los_a),
      .los_b     (los_b),
      .act_src   (act_src),
      .act_drive (act_drive),
      .hold      (hold),
      .sw_pulse  (sw_pulse),
      .out_en    (out_en)
   );

   // both references share one phase so they qualify on the same edge
   always @(posedge clk) begin
      ph    <= ph + 3'd1;
      ref_a <= run_a & ph[2];
      ref_b <= run_b & ph[2];
   end

   // R10 monitor: strobes against observed source changes
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (sw_pulse) pulses++;
         if (act_src != prev_act) changes++;
      end
      prev_act <= act_src;
   end

   // fields: mode[8:7] sel[6] run_a[5] run_b[4] los_a[3] los_b[2] act[1] hold[0]
   localparam int NV = 18;
   localparam logic [8:0] VEC [NV] = '{
      9'b00_0_11_00_0_0,
      9'b00_1_11_00_1_0,
      9'b00_1_10_01_1_0,
      9'b00_0_11_00_0_0,
      9'b10_0_01_10_1_0,
      9'b10_0_11_00_0_0,
      9'b01_0_01_10_1_0,
      9'b01_0_11_00_1_0,
      9'b01_0_10_01_0_0,
      9'b01_0_11_00_0_0,
      9'b10_0_01_10_1_0,
      9'b10_0_00_11_1_1,
      9'b10_0_01_10_1_0,
      9'b10_0_11_00_0_0,
      9'b01_0_01_10_1_0,
      9'b01_0_00_11_1_1,
      9'b01_0_11_00_0_0,
      9'b00_0_11_00_0_0
   };

   function automatic string vec_tag(input int i);
      case (i)
         0, 1, 2, 3, 17:     return "R4 manual";
         4, 5, 10, 13:       return "R6 revertive";
         6, 7, 8, 9, 14:     return "R7 non-revertive";
         11, 15:             return "R8 hold";
         12:                 return "R9 hold exit to input 2";
         default:            return "R9 hold exit prefers input 1";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1 reset state
      cyc(5);
      chk("R1 out_en in reset", 32'(out_en), 32'd0);
      chk("R1 act_drive in reset", 32'(act_drive), 32'd0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 los_a after reset", 32'(los_a), 32'd1);
      chk("R1 los_b after reset", 32'(los_b), 32'd1);
      chk("R1 hold after reset", 32'(hold), 32'd1);
      chk("R1 act_src after reset", 32'(act_src), 32'd0);
      chk("R1 out_en after reset", 32'(out_en), 32'd1);
      mon_on = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         mode_sel = VEC[i][8:7];
         sel_in   = VEC[i][6];
         run_a    = VEC[i][5];
         run_b    = VEC[i][4];
         cyc(300);
         chk({vec_tag(i), " los_a"}, 32'(los_a), 32'(VEC[i][3]));
         chk({vec_tag(i), " los_b"}, 32'(los_b), 32'(VEC[i][2]));
         chk({vec_tag(i), " act_src"}, 32'(act_src), 32'(VEC[i][1]));
         chk({vec_tag(i), " hold"}, 32'(hold), 32'(VEC[i][0]));
         chk("R11 act_drive vs mode", 32'(act_drive), 32'(VEC[i][8:7] != 2'b00));
      end

      // R5 short pulse on the select is ignored
      sel_in = 1'b1;
      cyc(10);
      sel_in = 1'b0;
      cyc(40);
      chk("R5 short select pulse", 32'(act_src), 32'd0);
      // R5 held select takes effect only after the filter run
      sel_in = 1'b1;
      cyc(10);
      chk("R5 select not yet accepted", 32'(act_src), 32'd0);
      cyc(30);
      chk("R5 held select accepted", 32'(act_src), 32'd1);

      // R2 loss detection timing (revertive mode)
      mode_sel = 2'b10;
      cyc(5);
      run_a = 1'b0;
      cyc(12);
      chk("R2 no alarm inside timeout", 32'(los_a), 32'd0);
      cyc(38);
      chk("R2 alarm after timeout", 32'(los_a), 32'd1);
      chk("R6 moved to input 2", 32'(act_src), 32'd1);

      // R3 short burst does not clear the alarm
      run_a = 1'b1;
      cyc(60);
      chk("R3 alarm held during short burst", 32'(los_a), 32'd1);
      run_a = 1'b0;
      cyc(150);
      chk("R3 alarm held after burst", 32'(los_a), 32'd1);
      run_a = 1'b1;
      cyc(300);
      chk("R3 alarm cleared after qualification", 32'(los_a), 32'd0);
      chk("R6 back on input 1", 32'(act_src), 32'd0);

      // R10 strobe count equals source changes
      chk("R10 strobes vs changes", 32'(pulses), 32'(changes));
      chk("R10 strobes seen", 32'(pulses > 10), 32'd1);

      // R1 reset in operation
      mon_on = 1'b0;
      rst_n = 1'b0;
      cyc(5);
      chk("R1 out_en during reset", 32'(out_en), 32'd0);
      chk("R1 act_drive during reset", 32'(act_drive), 32'd0);
      run_a = 1'b0;
      run_b = 1'b0;
      rst_n = 1'b1;
      cyc(1);
      chk("R1 alarms after re-reset", 32'({los_a, los_b}), 32'd3);
      chk("R1 hold after re-reset", 32'(hold), 32'd1);

      finish_run();
   end

endmodule